// File: doc/BRIEF.md
# Adaptive Clock-Gating Threshold Controller

This block chooses how many multi-threaded processing elements in a packet engine keep their clocks running. It samples two on-chip signals every cycle: the number of threads parked in the idle queue waiting for a packet, and a full flag from the receive packet buffer. When the idle queue keeps at least one element's worth of threads for a large part of an observation window, the controller gates the clock of one element at the end of that window. When the receive buffer fills, it brings one gated element back at once.

The decision threshold adapts itself. Each window it moves down by a fixed step if the buffer never filled, so gating becomes more aggressive. If the buffer filled at least once, it moves up by the same step, so gating becomes more cautious. The outputs are a clock-enable vector with one bit per element and one-cycle pulses marking each gate-off and each wake-up. Thread draining and the clock-gate cells are outside the block.

Top module: `pe_gate_ctrl`

## Requirements
- R1: A window lasts WINDOW clock cycles, counted from the first cycle after reset. Within a window the block counts the cycles in which `idle_len` is greater than or equal to THREADS. The count starts again from zero in each new window, and cycles with `idle_len` below THREADS are not counted.
- R2: On the last cycle of a window, if the count for that window, including that last cycle, is strictly greater than the current threshold, the highest-indexed enabled element is disabled. `off_req` is high for exactly one cycle, from that clock edge onward.
- R3: A rising edge of `buf_full` re-enables the lowest-indexed disabled element on the same clock edge and pulses `on_req` for one cycle. If every element is already enabled, there is no pulse and no change.
- R4: After reset the threshold is WINDOW/2. The adjustment step is WINDOW/50, and never less than 1.
- R5: At each window end the threshold rises by the step if `buf_full` was high in any cycle of that window, and falls by the step otherwise. It does not change in any other cycle.
- R6: The threshold saturates at WINDOW on the way up and at 0 on the way down.
- R7: At least one element always stays enabled. A gate-off decision while only element 0 is enabled produces no `off_req` pulse and no change.
- R8: If a `buf_full` rising edge falls on the same cycle as a window-end gate-off decision, the gate-off is dropped. Only the wake-up, if one is possible, takes effect.
- R9: During reset every element is enabled, and `off_req` and `on_req` are low.
- R10: Bit i of `pe_en` is the clock enable of element i. The enabled elements always form a contiguous run starting at bit 0, and at most one bit changes per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_len | input | QLEN_W | Current number of idle threads waiting for a packet |
| buf_full | input | 1 | Receive packet buffer full flag |
| pe_en | output | NUM_PE | Clock enable per element; bit i drives element i |
| off_req | output | 1 | One-cycle pulse when an element is gated off |
| on_req | output | 1 | One-cycle pulse when an element is re-enabled |

## Verification
The hardest states to reach are the two threshold limits. The threshold is not visible at the ports, and reaching either limit from the start value takes about twenty-five windows of one kind in a row. The bench shrinks the window to 100 cycles, which gives a step of 2. It then drives thirty windows that all contain a full pulse, or thirty that contain none. It detects the clamped value by which idle-cycle count produces a gate-off in the next windows: with saturation the threshold stops at 100 or 0, while an unclamped threshold would keep moving and shift which counts trigger a gate-off. Same-cycle collisions are produced by placing the full pulse on the last cycle of a window that already qualifies for gating.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

   typedef enum logic [1:0] {
      PGC_HOLD = 2'd0,
      PGC_GATE = 2'd1,
      PGC_WAKE = 2'd2
   } pgc_act_e;

   // adjustment step: one fiftieth of the window, never zero
   function automatic int unsigned pgc_step(input int unsigned window);
      return (window / 50 == 0) ? 1 : window / 50;
   endfunction

endpackage

// File: rtl/pgc_window.sv
module pgc_window #(
   parameter int unsigned WINDOW  = 1000000,
   parameter int unsigned CNT_W   = 20,
   parameter int unsigned QLEN_W  = 5,
   parameter int unsigned THREADS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [QLEN_W-1:0] idle_len,
   output logic              win_end,
   output logic [CNT_W-1:0]  occ_total
);
   localparam logic [CNT_W-1:0]  LAST = CNT_W'(WINDOW - 1);
   localparam logic [QLEN_W-1:0] TLIM = QLEN_W'(THREADS);

   logic [CNT_W-1:0] pos_q;
   logic [CNT_W-1:0] occ_q;
   logic             hit;

   assign hit       = (idle_len >= TLIM);
   assign win_end   = (pos_q == LAST);
   assign occ_total = occ_q + {{(CNT_W-1){1'b0}}, hit};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= '0;
         occ_q <= '0;
      end else begin
         pos_q <= win_end ? '0 : pos_q + 1'b1;
         occ_q <= win_end ? '0 : occ_total;
      end
   end

   AST_OCC_LE_POS: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= pos_q);                                           // R1
   AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> (pos_q == '0) && (occ_q == '0));               // R1

endmodule

// File: rtl/pgc_thresh.sv
module pgc_thresh
   import pgc_pkg::*;
#(
   parameter int unsigned WINDOW = 1000000,
   parameter int unsigned CNT_W  = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_end,
   input  logic             buf_full,
   output logic [CNT_W-1:0] th
);
   localparam int unsigned      STEP = pgc_step(WINDOW);
   localparam logic [CNT_W-1:0] TOP  = CNT_W'(WINDOW);
   localparam logic [CNT_W-1:0] STP  = CNT_W'(STEP);
   localparam logic [CNT_W-1:0] INIT = CNT_W'(WINDOW / 2);

   logic [CNT_W-1:0] th_q;
   logic [CNT_W-1:0] th_up;
   logic [CNT_W-1:0] th_dn;
   logic             seen_q;
   logic             seen_any;

   assign seen_any = seen_q | buf_full;
   // compare before adding so the sum can never wrap
   assign th_up    = (th_q > TOP - STP) ? TOP : th_q + STP;
   assign th_dn    = (th_q < STP) ? '0 : th_q - STP;
   assign th       = th_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         th_q   <= INIT;
         seen_q <= 1'b0;
      end else if (win_end) begin
         th_q   <= seen_any ? th_up : th_dn;
         seen_q <= 1'b0;
      end else begin
         seen_q <= seen_any;
      end
   end

   AST_TH_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      th_q <= TOP);                                              // R6
   AST_TH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> $stable(th_q));                               // R5
   AST_TH_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> (th_q != $past(th_q)) || (th_q == TOP) || (th_q == '0)); // R5

endmodule

// File: rtl/pgc_mask.sv
module pgc_mask
   import pgc_pkg::*;
#(
   parameter int unsigned NUM_PE = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              want_off,
   input  logic              want_on,
   output logic [NUM_PE-1:0] pe_en,
   output logic              off_req,
   output logic              on_req
);
   localparam int unsigned KW   = $clog2(NUM_PE + 1);
   localparam logic [KW-1:0] KMAX = KW'(NUM_PE);
   localparam logic [KW-1:0] KONE = KW'(1);

   logic [KW-1:0] k_q;
   pgc_act_e      act;

   // a buffer-full edge always suppresses a gate-off in the same cycle
   always_comb begin
      act = PGC_HOLD;
      if (want_on) begin
         if (k_q != KMAX) act = PGC_WAKE;
      end else if (want_off && (k_q > KONE)) begin
         act = PGC_GATE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         k_q     <= KMAX;
         off_req <= 1'b0;
         on_req  <= 1'b0;
      end else begin
         off_req <= (act == PGC_GATE);
         on_req  <= (act == PGC_WAKE);
         case (act)
            PGC_WAKE: k_q <= k_q + 1'b1;
            PGC_GATE: k_q <= k_q - 1'b1;
            default:  k_q <= k_q;
         endcase
      end
   end

   for (genvar gi = 0; gi < NUM_PE; gi++) begin : g_en
      assign pe_en[gi] = (k_q > KW'(gi));
   end

   AST_KEEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pe_en) >= 1);                                   // R7
   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pe_en ^ $past(pe_en)) <= 1);                    // R10
   AST_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
      ((pe_en + NUM_PE'(1)) & pe_en) == '0);                     // R10
   AST_OFF_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      off_req |-> ($countones(pe_en) + 1 == $countones($past(pe_en)))); // R2
   AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !(off_req && on_req));                                     // R8

endmodule

// File: rtl/pe_gate_ctrl.sv
module pe_gate_ctrl #(
   parameter int unsigned NUM_PE  = 6,
   parameter int unsigned THREADS = 4,
   parameter int unsigned QLEN_W  = 5,
   parameter int unsigned WINDOW  = 1000000,
   parameter int unsigned CNT_W   = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [QLEN_W-1:0] idle_len,
   input  logic              buf_full,
   output logic [NUM_PE-1:0] pe_en,
   output logic              off_req,
   output logic              on_req
);
   if (NUM_PE < 2) begin : g_chk_pe
      $error("pe_gate_ctrl: NUM_PE must be at least 2");
   end
   if (WINDOW < 2 || 64'(WINDOW) >= (64'(1) << CNT_W)) begin : g_chk_win
      $error("pe_gate_ctrl: WINDOW must fit in CNT_W bits");
   end
   if (THREADS < 1 || 64'(THREADS) >= (64'(1) << QLEN_W)) begin : g_chk_thr
      $error("pe_gate_ctrl: THREADS must fit in QLEN_W bits");
   end

   logic             win_end;
   logic [CNT_W-1:0] occ_total;
   logic [CNT_W-1:0] th;
   logic             full_q;
   logic             want_on;
   logic             want_off;

   always_ff @(posedge clk) begin
      if (!rst_n) full_q <= 1'b0;
      else        full_q <= buf_full;
   end

   assign want_on  = buf_full & ~full_q;
   assign want_off = win_end & (occ_total > th);

   pgc_window #(
      .WINDOW (WINDOW),
      .CNT_W  (CNT_W),
      .QLEN_W (QLEN_W),
      .THREADS(THREADS)
   ) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle_len (idle_len),
      .win_end  (win_end),
      .occ_total(occ_total)
   );

   pgc_thresh #(
      .WINDOW(WINDOW),
      .CNT_W (CNT_W)
   ) u_thresh (
      .clk     (clk),
      .rst_n   (rst_n),
      .win_end (win_end),
      .buf_full(buf_full),
      .th      (th)
   );

   pgc_mask #(
      .NUM_PE(NUM_PE)
   ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .want_off(want_off),
      .want_on (want_on),
      .pe_en   (pe_en),
      .off_req (off_req),
      .on_req  (on_req)
   );

   AST_WAKE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(buf_full) && !(&pe_en)) |=> on_req);                // R3

endmodule

// File: tb/pe_gate_ctrl_tb.sv
`timescale 1ns/1ps
module pe_gate_ctrl_tb;
   localparam int NPE = 6;
   localparam int THR = 4;
   localparam int QW  = 5;
   localparam int P   = 100;
   localparam int ALL = (1 << NPE) - 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [QW-1:0] idle_len;
   logic          buf_full;
   logic [NPE-1:0] pe_en;
   logic          off_req;
   logic          on_req;

   int n_tests = 0;
   int n_fail  = 0;
   int probe_en;
   int probe_on;

   always #10 clk = ~clk;

   pe_gate_ctrl #(
      .NUM_PE(NPE), .THREADS(THR), .QLEN_W(QW), .WINDOW(P), .CNT_W(20)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .idle_len(idle_len), .buf_full(buf_full),
      .pe_en(pe_en), .off_req(off_req), .on_req(on_req)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; idle_len = '0; buf_full = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // drives one full window; returns at the negedge after its last edge
   task automatic run_window(input int hits, input int qv, input int full_at);
      for (int i = 0; i < P; i++) begin
         idle_len = (i < hits) ? QW'(qv) : '0;
         buf_full = (i == full_at);
         @(negedge clk);
         if (i == full_at) begin
            probe_en = int'(pe_en);
            probe_on = int'(on_req);
         end
      end
      idle_len = '0; buf_full = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R9", "pe_en after reset", int'(pe_en), ALL);
      chk("R9", "off_req after reset", int'(off_req), 0);
      chk("R9", "on_req after reset", int'(on_req), 0);
   endtask

   task automatic t_gate_off();
      do_reset();
      run_window(51, THR, -1);
      chk("R2", "gate top element", int'(pe_en), 'h1F);
      chk("R2", "off pulse", int'(off_req), 1);
      @(negedge clk);
      chk("R2", "off pulse one cycle", int'(off_req), 0);
   endtask

   task automatic t_below_t();
      do_reset();
      run_window(P, THR - 1, -1);
      chk("R1", "below THREADS not counted", int'(pe_en), ALL);
      run_window(P, THR + 5, -1);
      chk("R1", "above THREADS counted", int'(pe_en), 'h1F);
   endtask

   task automatic t_strict_lower();
      do_reset();
      run_window(50, THR, -1);
      chk("R4", "count equal to start threshold", int'(pe_en), ALL);
      run_window(49, THR, -1);
      chk("R5", "lowered threshold gates", int'(pe_en), 'h1F);
   endtask

   task automatic t_clear();
      do_reset();
      run_window(40, THR, -1);
      chk("R1", "window one no gate", int'(pe_en), ALL);
      run_window(40, THR, -1);
      chk("R1", "count cleared between windows", int'(pe_en), ALL);
   endtask

   task automatic t_raise();
      do_reset();
      run_window(0, THR, 0);
      chk("R3", "wake with all enabled no pulse", probe_on, 0);
      chk("R3", "wake with all enabled no change", probe_en, ALL);
      run_window(52, THR, -1);
      chk("R5", "raised threshold holds", int'(pe_en), ALL);
      run_window(51, THR, -1);
      chk("R5", "threshold back to 50", int'(pe_en), 'h1F);
   endtask

   task automatic t_wake();
      do_reset();
      run_window(P, THR, -1);
      run_window(P, THR, -1);
      chk("R2", "two gated", int'(pe_en), 'h0F);
      run_window(0, THR, 10);
      chk("R3", "wake lowest gated immediately", probe_en, 'h1F);
      chk("R3", "on pulse", probe_on, 1);
      chk("R3", "on pulse gone at window end", int'(on_req), 0);
   endtask

   task automatic t_floor();
      do_reset();
      for (int k = NPE - 1; k >= 1; k--) begin
         run_window(P, THR, -1);
         chk("R10", "contiguous prefix", int'(pe_en), (1 << k) - 1);
      end
      run_window(P, THR, -1);
      chk("R7", "last element kept", int'(pe_en), 1);
      chk("R7", "no off pulse at floor", int'(off_req), 0);
   endtask

   task automatic t_collide();
      do_reset();
      run_window(P, THR, -1);
      run_window(P, THR, P - 1);
      chk("R8", "wake wins over gate", int'(pe_en), ALL);
      chk("R8", "on pulse", int'(on_req), 1);
      chk("R8", "no off pulse", int'(off_req), 0);
   endtask

   task automatic t_ceiling();
      do_reset();
      for (int w = 0; w < 30; w++) run_window(0, THR, 0);
      run_window(P, THR, -1);
      chk("R6", "threshold capped at WINDOW", int'(pe_en), ALL);
      run_window(P - 1, THR, -1);
      chk("R6", "threshold falls from cap", int'(pe_en), 'h1F);
   endtask

   task automatic t_zero();
      do_reset();
      for (int w = 0; w < 30; w++) run_window(0, THR, -1);
      run_window(0, THR, -1);
      chk("R6", "zero count never gates", int'(pe_en), ALL);
      run_window(1, THR, -1);
      chk("R6", "threshold floored at zero", int'(pe_en), 'h1F);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_gate_off();
      t_below_t();
      t_strict_lower();
      t_clear();
      t_raise();
      t_wake();
      t_floor();
      t_collide();
      t_ceiling();
      t_zero();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule